// File: doc/BRIEF.md
# Processor-Hot Event Masking Controller

This block collects eight processor-hot trigger sources and turns the enabled ones into a sticky status vector and an active-low alert pin. Five of the sources are level conditions that the surrounding analog front end supplies: input-voltage droop, comparator trip, critical current, nominal current and system-voltage low. A sixth comes from inside the block. It compares a digital battery discharge current in milliamps against a programmable threshold, and the result must hold without a break for a selectable time before it counts. The last two sources fire once. A falling battery-present input or a falling adapter-OK input starts a fixed-length alert pulse.

A 16-bit control word sets the threshold, the deglitch time and one enable per source. A disabled source changes neither the status nor the pin. Status bits stay set until the host clears them by writing ones. Deglitch time is counted in pulses of a microsecond tick input, and the tick count for each select code is a parameter.

Top module: `hot_alert_top`

## Requirements
- R1: After reset the control word reads 0x81A0, the status vector is all zero and `alertN` is high.
- R2: When `cfgWrEn` is high at a clock edge, `cfgWord` shows `cfgWrData` from the next cycle on. Bits 15:10 hold the threshold code, bits 9:8 the deglitch select and bits 7:0 the enables. Enable and status bit positions are 7 droop, 6 comparator, 5 critical current, 4 nominal current, 3 discharge current, 2 system voltage, 1 battery presence, 0 adapter-OK.
- R3: The discharge condition is true only while `dischgMa` is strictly greater than code*512 + 128 mA. Equality does not trip it.
- R4: The discharge source becomes live after the condition has held across N `usTick` pulses, where select 00 gives DG_T00 (2000), 01 gives DG_T01 (130), 10 gives DG_T10 (8000) and 11 gives DG_T11 (16000). Any cycle without the condition drops the source and restarts the count. Once live, the source sets status and alert with one more cycle of latency.
- R5: Level inputs map as `levelSrc[4]` droop, `[3]` comparator, `[2]` critical, `[1]` nominal and `[0]` system voltage. While one of them is high and its enable is set, the matching status bit is set and `alertN` is low, each one cycle after the input.
- R6: A source whose enable bit is 0 sets no status bit and never pulls `alertN` low.
- R7: If all eight enables were 0 in the previous cycle, `alertN` is high.
- R8: When `batPresent` falls while enable bit 1 is set, status bit 1 is set and `alertN` is low for exactly PULSE_CYC cycles, starting one cycle after the edge. Clearing the enable stops the pulse.
- R9: When `adapterOk` falls while enable bit 0 is set, the same happens with status bit 0.
- R10: Status bits are sticky. A cycle with `statClrEn` high clears the bits set in `statClrMask`. An event in the same cycle keeps its bit set.
- R11: A rising edge or a steady level on `batPresent` or `adapterOk` produces no status bit and no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 16 | Control word write value |
| cfgWord | output | 16 | Current control word |
| statClrEn | input | 1 | Status clear strobe |
| statClrMask | input | 8 | Write-one-to-clear mask for status |
| usTick | input | 1 | One-cycle microsecond tick |
| dischgMa | input | 16 | Measured battery discharge current in mA |
| levelSrc | input | 5 | Level source conditions (droop, comparator, critical, nominal, system voltage) |
| batPresent | input | 1 | Battery present, high when fitted |
| adapterOk | input | 1 | Adapter good, high when attached |
| statusOut | output | 8 | Sticky event status |
| alertN | output | 1 | Active-low processor-hot alert |

## Verification
The discharge path is driven at exactly the threshold and one milliamp above it, so a non-strict compare shows up. Over-threshold bursts are applied both unbroken and broken by a single low cycle, under all four select codes, so a counter that fails to restart or picks the wrong select shows up. Random level sources run under random enable masks, including the all-zero mask, and this separates masking of status from masking of the pin. The presence inputs see falling, rising and steady patterns, and host clears are timed to land on the same cycle as events, which checks edge polarity, pulse length and the rule that a new event beats a clear.

// File: rtl/hot_alert_pkg.sv
package hot_alert_pkg;
  localparam int CFG_W  = 16;
  localparam int SRC_N  = 8;
  localparam int LVL_N  = 5;
  localparam int THR_LSB = 10;
  localparam int THR_W   = 6;
  localparam int DG_LSB  = 8;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h81A0;

  // status / enable bit positions (priority-free, fixed by the word layout)
  localparam int B_DROOP = 7;
  localparam int B_COMP  = 6;
  localparam int B_CRIT  = 5;
  localparam int B_NOM   = 4;
  localparam int B_DCHG  = 3;
  localparam int B_SYS   = 2;
  localparam int B_BAT   = 1;
  localparam int B_AC    = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic             dgHit;     // deglitched discharge condition
    logic [1:0]       oneShot;   // enabled removal edges {battery, adapter}
    logic             pulseHold; // a one-shot pulse is running next cycle
    logic [SRC_N-1:0] clrBits;   // status bits to clear this cycle
  } hot_strobe_t;
endpackage

// File: rtl/hot_alert_ctl.sv
module hot_alert_ctl
  import hot_alert_pkg::*;
#(
  parameter int DG_T00    = 2000,
  parameter int DG_T01    = 130,
  parameter int DG_T10    = 8000,
  parameter int DG_T11    = 16000,
  parameter int PULSE_CYC = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             usTick,
  input  logic             overThr,
  input  logic             batPresent,
  input  logic             adapterOk,
  input  logic             statClrEn,
  input  logic [SRC_N-1:0] statClrMask,
  output logic [CFG_W-1:0] cfgQ,
  output hot_strobe_t      strb
);
  localparam int DG_MAXA = (DG_T00 > DG_T01) ? DG_T00 : DG_T01;
  localparam int DG_MAXB = (DG_T10 > DG_T11) ? DG_T10 : DG_T11;
  localparam int DG_MAX  = (DG_MAXA > DG_MAXB) ? DG_MAXA : DG_MAXB;
  localparam int DG_W    = $clog2(DG_MAX + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);

  logic [DG_W-1:0] dgCnt;
  logic [DG_W-1:0] dgLim;
  logic            dgHit;
  logic [1:0]      remIn;
  logic [1:0]      remPrev;
  logic [1:0]      remFall;
  logic [1:0]      chanEn;
  logic [1:0]      pulseLive;

  // control word register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= CFG_RST;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgQ == $past(cfgWrData))); // R2

  // deglitch limit from the select code
  always_comb begin
    unique case (cfgQ[DG_LSB +: 2])
      2'b00:   dgLim = DG_W'(DG_T00);
      2'b01:   dgLim = DG_W'(DG_T01);
      2'b10:   dgLim = DG_W'(DG_T10);
      default: dgLim = DG_W'(DG_T11);
    endcase
  end

  // tick counter; any gap in the condition restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dgCnt <= '0;
      dgHit <= 1'b0;
    end else if (!overThr) begin
      dgCnt <= '0;
      dgHit <= 1'b0;
    end else if (!dgHit && usTick) begin
      if (dgCnt + DG_W'(1) >= dgLim) dgHit <= 1'b1;
      else                           dgCnt <= dgCnt + DG_W'(1);
    end
  end

  AST_DG_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !overThr |=> (!dgHit && dgCnt == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    dgCnt < DG_W'(DG_MAX)); // R4

  // removal edge detection
  assign remIn   = {batPresent, adapterOk};
  assign chanEn  = {cfgQ[B_BAT], cfgQ[B_AC]};
  assign remFall = remPrev & ~remIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remPrev <= '0;
    else       remPrev <= remIn;
  end

  // one pulse stretcher per removal channel
  for (genvar j = 0; j < 2; j++) begin : g_shot
    logic [PULSE_W-1:0] pulseCnt;
    logic [PULSE_W-1:0] pulseNext;

    always_comb begin
      if (!chanEn[j])                pulseNext = '0;
      else if (remFall[j])           pulseNext = PULSE_W'(PULSE_CYC);
      else if (pulseCnt != '0)       pulseNext = pulseCnt - PULSE_W'(1);
      else                           pulseNext = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseCnt <= '0;
      else       pulseCnt <= pulseNext;
    end

    assign pulseLive[j] = (pulseNext != '0);

    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (remFall[j] && chanEn[j]) |=> (pulseCnt == PULSE_W'(PULSE_CYC))); // R8 R9
    AST_PULSE_DROP: assert property (@(posedge clk) disable iff (!rstN)
      !chanEn[j] |=> (pulseCnt == '0)); // R8
  end

  assign strb.dgHit     = dgHit;
  assign strb.oneShot   = remFall & chanEn;
  assign strb.pulseHold = |pulseLive;
  assign strb.clrBits   = statClrEn ? statClrMask : '0;
endmodule

// File: rtl/hot_alert_dp.sv
module hot_alert_dp
  import hot_alert_pkg::*;
#(
  parameter int CUR_W   = 16,
  parameter int STEP_MA = 512,
  parameter int OFFS_MA = 128
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [THR_W-1:0] thrCode,
  input  logic [SRC_N-1:0] enMask,
  input  logic [CUR_W-1:0] dischgMa,
  input  logic [LVL_N-1:0] levelSrc,
  input  hot_strobe_t      strb,
  output logic             overThr,
  output logic [SRC_N-1:0] statusQ,
  output logic             alertN
);
  localparam int CMP_W = CUR_W + 1;

  logic [CMP_W-1:0] thrMa;
  logic [SRC_N-1:0] liveVec;
  logic [SRC_N-1:0] evtVec;
  logic             anyLive;

  // threshold in mA and strict compare
  assign thrMa   = CMP_W'(thrCode) * CMP_W'(STEP_MA) + CMP_W'(OFFS_MA);
  assign overThr = ({1'b0, dischgMa} > thrMa);

  // live conditions placed at their status positions
  always_comb begin
    liveVec          = '0;
    liveVec[B_DROOP] = levelSrc[4];
    liveVec[B_COMP]  = levelSrc[3];
    liveVec[B_CRIT]  = levelSrc[2];
    liveVec[B_NOM]   = levelSrc[1];
    liveVec[B_DCHG]  = strb.dgHit;
    liveVec[B_SYS]   = levelSrc[0];
  end

  assign evtVec  = (liveVec | {{(SRC_N-2){1'b0}}, strb.oneShot}) & enMask;
  assign anyLive = |(liveVec & enMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      alertN  <= 1'b1;
    end else begin
      statusQ <= (statusQ & ~strb.clrBits) | evtVec;
      alertN  <= ~(anyLive | strb.pulseHold);
    end
  end

  AST_MASKED_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(enMask)) == '0)); // R6
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |=> alertN); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> ((statusQ & $past(evtVec)) == $past(evtVec))); // R10
endmodule

// File: rtl/hot_alert_top.sv
module hot_alert_top
  import hot_alert_pkg::*;
#(
  parameter int CUR_W     = 16,
  parameter int STEP_MA   = 512,
  parameter int OFFS_MA   = 128,
  parameter int DG_T00    = 2000,
  parameter int DG_T01    = 130,
  parameter int DG_T10    = 8000,
  parameter int DG_T11    = 16000,
  parameter int PULSE_CYC = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [15:0]      cfgWrData,
  output logic [15:0]      cfgWord,
  input  logic             statClrEn,
  input  logic [7:0]       statClrMask,
  input  logic             usTick,
  input  logic [CUR_W-1:0] dischgMa,
  input  logic [4:0]       levelSrc,
  input  logic             batPresent,
  input  logic             adapterOk,
  output logic [7:0]       statusOut,
  output logic             alertN
);
  hot_strobe_t      strb;
  logic             overThr;
  logic [CFG_W-1:0] cfgQ;

  hot_alert_ctl #(
    .DG_T00(DG_T00), .DG_T01(DG_T01), .DG_T10(DG_T10), .DG_T11(DG_T11),
    .PULSE_CYC(PULSE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .usTick(usTick), .overThr(overThr),
    .batPresent(batPresent), .adapterOk(adapterOk),
    .statClrEn(statClrEn), .statClrMask(statClrMask),
    .cfgQ(cfgQ), .strb(strb)
  );

  hot_alert_dp #(
    .CUR_W(CUR_W), .STEP_MA(STEP_MA), .OFFS_MA(OFFS_MA)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .thrCode(cfgQ[THR_LSB +: THR_W]), .enMask(cfgQ[SRC_N-1:0]),
    .dischgMa(dischgMa), .levelSrc(levelSrc), .strb(strb),
    .overThr(overThr), .statusQ(statusOut), .alertN(alertN)
  );

  assign cfgWord = cfgQ;
endmodule

// File: tb/sim_hot_alert_top.sv
`timescale 1ns/1ps
module sim_hot_alert_top;
  localparam int P_T00 = 3, P_T01 = 5, P_T10 = 7, P_T11 = 9, P_PULSE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgWord;
  logic        statClrEn = 1'b0;
  logic [7:0]  statClrMask = '0;
  logic        usTick = 1'b0;
  logic [15:0] dischgMa = '0;
  logic [4:0]  levelSrc = '0;
  logic        batPresent = 1'b1;
  logic        adapterOk = 1'b1;
  logic [7:0]  statusOut;
  logic        alertN;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference state
  logic [15:0] mCfg;
  logic [7:0]  mStat;
  logic        mAlertN, mDg, mPrevBat, mPrevAc;
  int          mDgCnt;
  int          mPulse[2];

  always #5 clk = ~clk;

  hot_alert_top #(
    .DG_T00(P_T00), .DG_T01(P_T01), .DG_T10(P_T10), .DG_T11(P_T11),
    .PULSE_CYC(P_PULSE)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgWord(cfgWord), .statClrEn(statClrEn), .statClrMask(statClrMask),
    .usTick(usTick), .dischgMa(dischgMa), .levelSrc(levelSrc),
    .batPresent(batPresent), .adapterOk(adapterOk),
    .statusOut(statusOut), .alertN(alertN)
  );

  function automatic int limOf(logic [1:0] s);
    case (s)
      2'b00:   return P_T00;
      2'b01:   return P_T01;
      2'b10:   return P_T10;
      default: return P_T11;
    endcase
  endfunction

  function automatic int thrOf(logic [15:0] c);
    return int'(c[15:10]) * 512 + 128;
  endfunction

  task automatic modelReset();
    mCfg = 16'h81A0; mStat = '0; mAlertN = 1'b1; mDg = 1'b0; mDgCnt = 0;
    mPrevBat = 1'b0; mPrevAc = 1'b0; mPulse[0] = 0; mPulse[1] = 0;
  endtask

  // one clock of the reference, from inputs held across the edge
  task automatic modelStep();
    logic [7:0] live, en, evt, clr;
    logic [1:0] fall, os;
    logic over, nDg, anyPulse;
    int nCnt;
    int np[2];
    en   = mCfg[7:0];
    over = int'(dischgMa) > thrOf(mCfg);
    live = {levelSrc[4:1], mDg, levelSrc[0], 2'b00};
    fall = {mPrevBat & ~batPresent, mPrevAc & ~adapterOk};
    os   = fall & en[1:0];
    anyPulse = 1'b0;
    for (int j = 0; j < 2; j++) begin
      if (!en[j])          np[j] = 0;
      else if (os[j])      np[j] = P_PULSE;
      else if (mPulse[j] > 0) np[j] = mPulse[j] - 1;
      else                 np[j] = 0;
      if (np[j] != 0) anyPulse = 1'b1;
    end
    evt = (live | {6'b0, os}) & en;
    clr = statClrEn ? statClrMask : 8'h00;
    nDg = mDg; nCnt = mDgCnt;
    if (!over) begin nDg = 1'b0; nCnt = 0; end
    else if (!mDg && usTick) begin
      if (mDgCnt + 1 >= limOf(mCfg[9:8])) nDg = 1'b1;
      else nCnt = mDgCnt + 1;
    end
    mAlertN = !((|(live & en)) || anyPulse);
    mStat   = (mStat & ~clr) | evt;
    mDg = nDg; mDgCnt = nCnt;
    mPulse[0] = np[0]; mPulse[1] = np[1];
    mPrevBat = batPresent; mPrevAc = adapterOk;
    if (cfgWrEn) mCfg = cfgWrData;
  endtask

  task automatic compare(string tag);
    vectors++;
    if (cfgWord !== mCfg || statusOut !== mStat || alertN !== mAlertN) begin
      miscompares++;
      $display("FAIL %s t=%0t cfg=%h/%h status=%b/%b alertN=%b/%b (actual/expected)",
               tag, $time, cfgWord, mCfg, statusOut, mStat, alertN, mAlertN);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic writeCfg(logic [15:0] w, string tag);
    cfgWrEn = 1'b1; cfgWrData = w;
    step(tag);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearAll(string tag);
    statClrEn = 1'b1; statClrMask = 8'hFF;
    step(tag);
    statClrEn = 1'b0; statClrMask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    compare("R1");               // reset values while held in reset
    rstN = 1'b1;
    step("R1");

    // R2: control word writes
    for (int i = 0; i < 20; i++) writeCfg(16'($urandom), "R2");
    writeCfg(16'h0000, "R2");

    // R3 / R4: threshold equality and deglitch per select code
    for (int s = 0; s < 4; s++) begin
      writeCfg({6'd2, 2'(s), 8'h08}, "R4");
      clearAll("R4");
      usTick = 1'b1;
      dischgMa = 16'd1152;                           // equal: must not trip
      repeat (14) step("R3");
      dischgMa = 16'd1153;
      repeat (2) step("R4");
      dischgMa = 16'd1000;                           // break restarts
      step("R4");
      dischgMa = 16'd1153;
      repeat (limOf(2'(s)) + 3) step("R4");
      usTick = 1'b0;
      repeat (2) step("R4");
      dischgMa = 16'd0;
      step("R4");
      for (int k = 0; k < 30; k++) begin
        usTick = 1'($urandom_range(0, 1));
        dischgMa = 16'(1150 + $urandom_range(0, 5));
        step("R4");
      end
      dischgMa = 16'd0; usTick = 1'b0;
    end

    // R5: level sources with all level enables on
    writeCfg(16'h00F4, "R5");
    clearAll("R5");
    for (int k = 0; k < 200; k++) begin
      levelSrc = 5'($urandom);
      if (k % 7 == 0) begin statClrEn = 1'b1; statClrMask = 8'($urandom); end
      step("R5");
      statClrEn = 1'b0;
    end

    // R6: random masks with random levels
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0) writeCfg({8'h00, 8'($urandom) & 8'hF4}, "R6");
      levelSrc = 5'($urandom);
      if (k % 11 == 0) begin statClrEn = 1'b1; statClrMask = 8'hFF; end
      step("R6");
      statClrEn = 1'b0;
    end

    // R7: everything active, all enables off
    writeCfg(16'hFF00, "R7");
    clearAll("R7");
    for (int k = 0; k < 100; k++) begin
      levelSrc = 5'($urandom); batPresent = 1'($urandom); adapterOk = 1'($urandom);
      usTick = 1'b1; dischgMa = 16'hFFFF;
      step("R7");
    end
    levelSrc = '0; dischgMa = '0; usTick = 1'b0; batPresent = 1'b1; adapterOk = 1'b1;

    // R8: battery removal pulse, then enable cleared mid-pulse
    writeCfg(16'h0002, "R8");
    clearAll("R8");
    repeat (2) step("R8");
    batPresent = 1'b0;
    repeat (P_PULSE + 3) step("R8");
    batPresent = 1'b1; step("R8");
    batPresent = 1'b0; step("R8");
    writeCfg(16'h0000, "R8");
    repeat (3) step("R8");
    batPresent = 1'b1;

    // R9: adapter removal pulse
    writeCfg(16'h0001, "R9");
    clearAll("R9");
    step("R9");
    adapterOk = 1'b0;
    repeat (P_PULSE + 3) step("R9");

    // R11: rising edges and steady levels
    writeCfg(16'h0003, "R11");
    batPresent = 1'b0; adapterOk = 1'b0; step("R11");
    clearAll("R11");
    repeat (P_PULSE + 1) step("R11");
    clearAll("R11");
    batPresent = 1'b1; adapterOk = 1'b1;
    repeat (P_PULSE + 3) step("R11");

    // R10: clears landing on events
    writeCfg(16'h00FF, "R10");
    for (int k = 0; k < 200; k++) begin
      levelSrc = 5'($urandom) & 5'($urandom);
      if (k % 5 == 0) batPresent = ~batPresent;
      if (k % 6 == 0) adapterOk = ~adapterOk;
      statClrEn = 1'($urandom); statClrMask = 8'($urandom);
      step("R10");
    end
    statClrEn = 1'b0;

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 15) == 0) begin cfgWrEn = 1'b1; cfgWrData = 16'($urandom); end
      else cfgWrEn = 1'b0;
      levelSrc = 5'($urandom) & 5'($urandom);
      usTick = 1'($urandom);
      if ($urandom_range(0, 1) == 0) dischgMa = 16'(thrOf(mCfg) + int'($urandom_range(0, 4)) - 2);
      else if ($urandom_range(0, 7) == 0) dischgMa = 16'($urandom);
      if ($urandom_range(0, 7) == 0) batPresent = ~batPresent;
      if ($urandom_range(0, 7) == 0) adapterOk = ~adapterOk;
      statClrEn = ($urandom_range(0, 7) == 0); statClrMask = 8'($urandom);
      step("R5");
    end
    cfgWrEn = 1'b0; statClrEn = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule